// File: doc/BRIEF.md
# Coprocessor Stack-Transfer Primitive Executor

This block sits on the main-processor side of a coprocessor link. It receives a 16-bit response primitive word from the coprocessor, together with a flag that says whether a conditional-category instruction is in progress and the current value of the active stack pointer. When the word encodes a top-of-stack transfer, the block validates it. It then moves one operand between the top of the stack and the coprocessor operand register, and reports the adjusted stack pointer.

A pop (direction bit clear) reads the stack at the current pointer and then advances the pointer. A push (direction bit set) lowers the pointer first and then writes the stack at the new address. One-byte operands still move the pointer by two, which keeps the stack word-aligned. A malformed or disallowed primitive ends with a one-cycle violation strobe and no memory traffic. The sibling single-register transfer primitive is recognised and passed out on its own strobe without any action.

Top module: `cp_stack_xfer`

## Requirements
- R1: A word is taken as a stack transfer only when bits 12..8 equal 01110 (binary) and the block is idle (`ready`=1). Bit 15 is the coprocessor-acknowledge flag, bit 13 the direction (0 pop, 1 push) and bits 7..0 the length in bytes. Bit 14 has no effect on the transfer.
- R2: If the acknowledge flag (bit 15) is 0 while `cond_cat`=1, the block pulses `viol`. It issues no memory request and no operand write, and `sp_out` equals the pointer it was given.
- R3: A length other than 1, 2 or 4 pulses `viol`. It issues no memory request and no operand write, and `sp_out` equals the pointer it was given.
- R4: A valid pop reads memory at the given pointer (`mem_we`=0). It writes the big-endian operand, right-justified and zero-extended, to `opr_wdata` with `opr_we`=1 in the `done` cycle. `sp_out` is the pointer plus the step.
- R5: A valid push lowers the pointer by the step first. It then writes `opr_rdata`, masked to the operand length and right-justified, at the new address (`mem_we`=1). `sp_out` is the lowered pointer.
- R6: The step is 2 for one-byte and two-byte operands and 4 for four-byte operands.
- R7: `mem_size` is 0 for one byte, 1 for two bytes and 2 for four bytes. A one-byte operand uses the single byte at the access address, which is the upper (even) byte of the stack word. Memory data is right-justified on `mem_wdata`/`mem_rdata`, with big-endian byte order in memory.
- R8: Every accepted stack primitive ends with exactly one one-cycle pulse, either `done` or `viol` and never both. `prim_valid` is ignored while `ready`=0.
- R9: A register-transfer word has bits 12..8 = 01100 and bits 7..4 = 0. In idle it raises `reg_hit` for one cycle, one cycle later. `reg_is_addr` carries bit 3 and `reg_num` carries bits 2..0. No transfer, `done` or `viol` follows.
- R10: While `mem_req`=1 and `mem_ack`=0, the values of `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` stay unchanged into the next cycle.
- R11: Words with any other type code cause no memory request, no pulse and no change of `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_valid | input | 1 | Primitive word is present |
| prim_word | input | 16 | Response primitive word |
| cond_cat | input | 1 | Conditional-category instruction active |
| sp_in | input | AW | Current active stack pointer |
| ready | output | 1 | Idle, able to accept a primitive |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_size | output | 2 | Access size: 0 byte, 1 two bytes, 2 four bytes |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| opr_rdata | input | 32 | Current operand register contents |
| opr_we | output | 1 | Operand register write strobe |
| opr_wdata | output | 32 | Operand register write data |
| sp_out | output | AW | Updated stack pointer, valid with done or viol |
| done | output | 1 | Transfer complete strobe |
| viol | output | 1 | Protocol violation strobe |
| reg_hit | output | 1 | Register-transfer primitive seen |
| reg_is_addr | output | 1 | Register-transfer: address (1) or data (0) register |
| reg_num | output | 3 | Register-transfer: register number |

## Verification
A wrong check or direction flag shows up at `done`/`viol` within two cycles of acceptance. It appears either as the wrong strobe or as a memory request that should not be there. A wrong step or adjust order shows in `mem_addr` on the first request cycle, and again in `sp_out` on the end pulse. Lane or byte-order errors show as wrong bytes in memory after a push, or in `opr_wdata` in the same cycle as `done` after a pop. The sweep covers every combination of direction, conditional flag, acknowledge flag and a set of legal and illegal lengths, under random wait states.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ADJUST,
    ST_ACCESS,
    ST_FIN
  } cpx_state_e;

  localparam logic [4:0] KIND_STACK = 5'b01110;
  localparam logic [4:0] KIND_REG   = 5'b01100;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_FULL = 2'd2;
endpackage

// File: rtl/cpx_kind.sv
module cpx_kind (
  input  logic [12:0] word_lo,
  output logic        is_stack,
  output logic        is_reg,
  output logic        reg_is_addr,
  output logic [2:0]  reg_num
);
  import cpx_pkg::*;

  always_comb begin
    is_stack    = (word_lo[12:8] == KIND_STACK);
    is_reg      = (word_lo[12:8] == KIND_REG) && (word_lo[7:4] == 4'd0);
    reg_is_addr = word_lo[3];
    reg_num     = word_lo[2:0];
  end
endmodule

// File: rtl/cpx_check.sv
module cpx_check #(
  parameter int AW = 16
) (
  input  logic          ca,
  input  logic          cond,
  input  logic [7:0]    len,
  output logic          bad,
  output logic [1:0]    size,
  output logic [AW-1:0] step
);
  import cpx_pkg::*;

  logic len_ok;

  always_comb begin
    len_ok = (len == 8'd1) || (len == 8'd2) || (len == 8'd4);
    bad    = !len_ok || (cond && !ca);
    case (len)
      8'd1:    size = SZ_BYTE;
      8'd2:    size = SZ_HALF;
      default: size = SZ_FULL;
    endcase
    step = (len == 8'd4) ? AW'(4) : AW'(2);
  end
endmodule

// File: rtl/cpx_lane.sv
module cpx_lane (
  input  logic [1:0]  size,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  import cpx_pkg::*;

  always_comb begin
    case (size)
      SZ_BYTE: dout = {24'd0, din[7:0]};
      SZ_HALF: dout = {16'd0, din[15:0]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/cp_stack_xfer.sv
module cp_stack_xfer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prim_valid,
  input  logic [15:0]   prim_word,
  input  logic          cond_cat,
  input  logic [AW-1:0] sp_in,
  output logic          ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic [31:0]   opr_rdata,
  output logic          opr_we,
  output logic [31:0]   opr_wdata,
  output logic [AW-1:0] sp_out,
  output logic          done,
  output logic          viol,
  output logic          reg_hit,
  output logic          reg_is_addr,
  output logic [2:0]    reg_num
);
  import cpx_pkg::*;

  cpx_state_e    st;
  logic          ca_r, dir_r, cond_r;
  logic [7:0]    len_r;
  logic [AW-1:0] sp_r, step_r;
  logic [1:0]    size_r;
  logic          bad_r;
  logic [31:0]   data_r;

  // Bit 14 carries no meaning for this primitive.
  logic unused_pc;
  assign unused_pc = prim_word[14];

  logic          in_stack, in_reg, in_reg_addr;
  logic [2:0]    in_reg_num;
  logic          chk_bad;
  logic [1:0]    chk_size;
  logic [AW-1:0] chk_step;
  logic [31:0]   push_data, pop_data;

  cpx_kind u_kind (
    .word_lo     (prim_word[12:0]),
    .is_stack    (in_stack),
    .is_reg      (in_reg),
    .reg_is_addr (in_reg_addr),
    .reg_num     (in_reg_num)
  );

  cpx_check #(.AW(AW)) u_check (
    .ca   (ca_r),
    .cond (cond_r),
    .len  (len_r),
    .bad  (chk_bad),
    .size (chk_size),
    .step (chk_step)
  );

  cpx_lane u_push_lane (
    .size (chk_size),
    .din  (opr_rdata),
    .dout (push_data)
  );

  cpx_lane u_pop_lane (
    .size (size_r),
    .din  (mem_rdata),
    .dout (pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ca_r        <= 1'b0;
      dir_r       <= 1'b0;
      cond_r      <= 1'b0;
      len_r       <= 8'd0;
      sp_r        <= '0;
      step_r      <= '0;
      size_r      <= SZ_BYTE;
      bad_r       <= 1'b0;
      data_r      <= 32'd0;
      opr_we      <= 1'b0;
      opr_wdata   <= 32'd0;
      reg_hit     <= 1'b0;
      reg_is_addr <= 1'b0;
      reg_num     <= 3'd0;
    end else begin
      opr_we  <= 1'b0;
      reg_hit <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (prim_valid && in_stack) begin
            ca_r   <= prim_word[15];
            dir_r  <= prim_word[13];
            len_r  <= prim_word[7:0];
            cond_r <= cond_cat;
            sp_r   <= sp_in;
            st     <= ST_CHECK;
          end else if (prim_valid && in_reg) begin
            reg_hit     <= 1'b1;
            reg_is_addr <= in_reg_addr;
            reg_num     <= in_reg_num;
          end
        end
        ST_CHECK: begin
          bad_r  <= chk_bad;
          size_r <= chk_size;
          step_r <= chk_step;
          data_r <= push_data;
          if (chk_bad)    st <= ST_FIN;
          else if (dir_r) st <= ST_ADJUST;
          else            st <= ST_ACCESS;
        end
        ST_ADJUST: begin
          sp_r <= sp_r - step_r;
          st   <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (mem_ack) begin
            if (!dir_r) begin
              opr_we    <= 1'b1;
              opr_wdata <= pop_data;
              sp_r      <= sp_r + step_r;
            end
            st <= ST_FIN;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (st == ST_IDLE);
  assign mem_req   = (st == ST_ACCESS);
  assign mem_we    = dir_r;
  assign mem_addr  = sp_r;
  assign mem_size  = size_r;
  assign mem_wdata = data_r;
  assign sp_out    = sp_r;
  assign done      = (st == ST_FIN) && !bad_r;
  assign viol      = (st == ST_FIN) && bad_r;

  // R8: never both strobes
  p_single_end_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && viol));

  // R8: end strobe lasts one cycle and returns to idle
  p_end_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (done || viol) |=> (!done && !viol && ready));

  // R10: request held until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_size) && $stable(mem_wdata)));

  // R5: pointer lowered before the push access
  p_push_predec_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADJUST) |=> (mem_req && mem_we && mem_addr == $past(sp_r) - $past(step_r)));

  // R3: a violation leaves the pointer and operand register untouched
  p_viol_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    viol |-> (!opr_we && $stable(sp_out)));

  // R9: register primitive only reported from idle, no transfer
  p_reg_idle_r9: assert property (@(posedge clk) disable iff (rst)
    reg_hit |-> (ready && !mem_req));
endmodule

// File: tb/cp_stack_xfer_bench.sv
`timescale 1ns/1ps
module cp_stack_xfer_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prim_valid = 1'b0;
  logic [15:0]   prim_word = 16'd0;
  logic          cond_cat = 1'b0;
  logic [AW-1:0] sp_in = '0;
  logic          ready, mem_req, mem_we;
  logic [1:0]    mem_size;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = 32'd0;
  logic          mem_ack = 1'b0;
  logic [31:0]   opr_rdata = 32'd0;
  logic          opr_we;
  logic [31:0]   opr_wdata;
  logic [AW-1:0] sp_out;
  logic          done, viol, reg_hit, reg_is_addr;
  logic [2:0]    reg_num;

  always #2.5 clk = ~clk;

  cp_stack_xfer #(.AW(AW)) u_cp_stack_xfer (
    .clk(clk), .rst(rst), .prim_valid(prim_valid), .prim_word(prim_word),
    .cond_cat(cond_cat), .sp_in(sp_in), .ready(ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .opr_rdata(opr_rdata), .opr_we(opr_we), .opr_wdata(opr_wdata),
    .sp_out(sp_out), .done(done), .viol(viol), .reg_hit(reg_hit),
    .reg_is_addr(reg_is_addr), .reg_num(reg_num)
  );

  int n_chk = 0, n_err = 0;
  int npulse = 0, nreq = 0, cyc = 0;
  int wcnt = 0;
  logic [7:0]    mem [0:255];
  logic          last_we = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic [1:0]    last_size = 2'd0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] be_read(input logic [7:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'd0, mem[a]};
      2'd1:    return {16'd0, mem[a], mem[8'(a+1)]};
      default: return {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
    endcase
  endfunction

  // Memory model with random wait states, driven away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt = $urandom_range(0, 3);
    end else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack <= 1'b1;
        nreq++;
        last_we = mem_we;
        last_addr = mem_addr;
        last_size = mem_size;
        if (mem_we) begin
          case (mem_size)
            2'd0: mem[mem_addr[7:0]] = mem_wdata[7:0];
            2'd1: begin
              mem[mem_addr[7:0]] = mem_wdata[15:8];
              mem[8'(mem_addr[7:0]+1)] = mem_wdata[7:0];
            end
            default: begin
              mem[mem_addr[7:0]] = mem_wdata[31:24];
              mem[8'(mem_addr[7:0]+1)] = mem_wdata[23:16];
              mem[8'(mem_addr[7:0]+2)] = mem_wdata[15:8];
              mem[8'(mem_addr[7:0]+3)] = mem_wdata[7:0];
            end
          endcase
        end else begin
          mem_rdata <= be_read(mem_addr[7:0], mem_size);
        end
      end else begin
        wcnt--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst) npulse += int'(done) + int'(viol);
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic wait_end(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done || viol) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  initial begin
    bit ok;
    int k = 0;
    int nreq0;
    logic [7:0] lens [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd8, 8'd255};
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk("R8 ready after reset", 32'(ready), 32'd1);
    chk("R8 done after reset", 32'(done), 32'd0);
    chk("R8 viol after reset", 32'(viol), 32'd0);
    chk("R10 mem_req after reset", 32'(mem_req), 32'd0);

    // Sweep: direction, conditional flag, ack flag, lengths (R1..R7)
    for (int dr = 0; dr < 2; dr++)
      for (int cnd = 0; cnd < 2; cnd++)
        for (int ca = 0; ca < 2; ca++)
          for (int li = 0; li < 8; li++) begin
            logic [7:0] len;
            logic [AW-1:0] sp, step;
            logic [1:0] sz;
            logic [31:0] val, exp;
            bit bad;
            len = lens[li];
            sp = AW'(16'h1080 + (k % 8) * 8);
            k++;
            val = $urandom();
            bad = (cnd == 1 && ca == 0) || !(len == 1 || len == 2 || len == 4);
            step = (len == 4) ? AW'(4) : AW'(2);
            sz = (len == 1) ? 2'd0 : (len == 2) ? 2'd1 : 2'd2;
            fill_mem();
            nreq0 = nreq;
            npulse = 0;
            @(negedge clk);
            prim_word = {1'(ca), 1'($urandom_range(0, 1)), 1'(dr), 5'b01110, len};
            cond_cat = 1'(cnd);
            sp_in = sp;
            opr_rdata = val;
            prim_valid = 1'b1;
            @(negedge clk);
            prim_valid = 1'b0;
            wait_end(ok);
            chk("R8 end reached", 32'(ok), 32'd1);
            if (bad) begin
              chk("R2/R3 viol", 32'(viol), 32'd1);
              chk("R3 no opr write", 32'(opr_we), 32'd0);
              chk("R3 sp unchanged", 32'(sp_out), 32'(sp));
              chk("R3 no request", 32'(nreq - nreq0), 32'd0);
            end else if (dr == 0) begin
              exp = be_read(sp[7:0], sz);
              chk("R4 done", 32'(done), 32'd1);
              chk("R4 opr_we", 32'(opr_we), 32'd1);
              chk("R4 opr data", opr_wdata, exp);
              chk("R6 pop sp", 32'(sp_out), 32'(sp + step));
              chk("R4 read addr", 32'(last_addr), 32'(sp));
              chk("R4 read dir", 32'(last_we), 32'd0);
              chk("R7 pop size", 32'(last_size), 32'(sz));
            end else begin
              exp = (sz == 2'd0) ? {24'd0, val[7:0]} : (sz == 2'd1) ? {16'd0, val[15:0]} : val;
              chk("R5 done", 32'(done), 32'd1);
              chk("R5 no opr write", 32'(opr_we), 32'd0);
              chk("R6 push sp", 32'(sp_out), 32'(sp - step));
              chk("R5 write addr", 32'(last_addr), 32'(sp - step));
              chk("R5 write dir", 32'(last_we), 32'd1);
              chk("R7 push size", 32'(last_size), 32'(sz));
              chk("R7 stack bytes", be_read(8'(sp - step), sz), exp);
            end
            repeat (2) @(negedge clk);
            chk("R8 one pulse", 32'(npulse), 32'd1);
          end

    // R8: prim_valid ignored while busy
    fill_mem();
    npulse = 0;
    @(negedge clk);
    prim_word = {3'b100, 5'b01110, 8'd4};
    cond_cat = 1'b0;
    sp_in = 16'h2040;
    prim_valid = 1'b1;
    @(negedge clk);
    prim_word = {3'b001, 5'b01110, 8'd3};
    sp_in = 16'h2000;
    wait_end(ok);
    prim_valid = 1'b0;
    chk("R8 busy end", 32'(done), 32'd1);
    chk("R8 busy sp", 32'(sp_out), 32'h2044);
    repeat (3) @(negedge clk);
    chk("R8 busy single pulse", 32'(npulse), 32'd1);

    // R9: register-transfer primitive
    npulse = 0;
    nreq0 = nreq;
    prim_word = {3'b101, 5'b01100, 4'd0, 1'b1, 3'd5};
    prim_valid = 1'b1;
    @(negedge clk);
    prim_valid = 1'b0;
    chk("R9 reg_hit", 32'(reg_hit), 32'd1);
    chk("R9 reg_is_addr", 32'(reg_is_addr), 32'd1);
    chk("R9 reg_num", 32'(reg_num), 32'd5);
    @(negedge clk);
    chk("R9 reg_hit one cycle", 32'(reg_hit), 32'd0);
    prim_word = {3'b000, 5'b01100, 4'd0, 1'b0, 3'd2};
    prim_valid = 1'b1;
    @(negedge clk);
    prim_valid = 1'b0;
    chk("R9 data reg", 32'(reg_is_addr), 32'd0);
    chk("R9 reg num 2", 32'(reg_num), 32'd2);
    prim_word = {3'b000, 5'b01100, 4'd3, 1'b0, 3'd2};
    prim_valid = 1'b1;
    @(negedge clk);
    prim_valid = 1'b0;
    chk("R9 nonzero upper bits rejected", 32'(reg_hit), 32'd0);
    repeat (4) @(negedge clk);
    chk("R9 no pulse", 32'(npulse), 32'd0);
    chk("R9 no request", 32'(nreq - nreq0), 32'd0);

    // R11: other type codes
    for (int t = 0; t < 32; t++) begin
      if (5'(t) == 5'b01110 || 5'(t) == 5'b01100) continue;
      npulse = 0;
      nreq0 = nreq;
      prim_word = {3'b100, 5'(t), 8'd2};
      prim_valid = 1'b1;
      @(negedge clk);
      prim_valid = 1'b0;
      chk("R11 ready kept", 32'(ready), 32'd1);
      repeat (2) @(negedge clk);
      chk("R11 no pulse", 32'(npulse + nreq - nreq0 + int'(reg_hit)), 32'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule